// File: doc/BRIEF.md
# ULPI Link Register Access Engine

This block sits on the link side of a ULPI-style transceiver interface and performs PHY register reads and writes. An internal requester presents an address, write data, a read/write flag and an extended-addressing flag. The engine then runs the full bus exchange: it sends the transmit command byte, sends a separate address byte when extended addressing is requested, and either transfers the write byte and closes it with a one-cycle stop strobe, or releases the bus and captures the byte the PHY returns.

The PHY owns the direction line and may take the bus at any time. If it raises direction while the link is still driving a register exchange, the engine lets go of the bus, waits until direction falls, and starts the same operation again from the command byte. It keeps doing this until the operation completes. The requester sees the exchange as one busy interval followed by a single done pulse, plus a read-data strobe for reads.

Top module: `ulpi_reg_engine`

## Requirements
- R1: During and right after reset, busy, done, read-valid, stop and output-enable are all low and the driven data byte is zero.
- R2: An immediate write drives the command byte {2'b10, addr[5:0]} until NXT is sampled high. It then drives the write byte until NXT is sampled high again. In the next cycle it drives zero with stop high for exactly one cycle, and done pulses in the cycle after that.
- R3: An immediate read drives the command byte {2'b11, addr[5:0]} until NXT is accepted and then stops driving. Direction sampled high marks the turnaround cycle. The data bus is captured at the next edge, and done, read-valid and the captured byte appear in the following cycle.
- R4: An extended operation puts address code 6'h2F in the low six bits of the command byte. Once NXT accepts the command, the engine drives the full 8-bit address as its own byte, and after a second NXT it continues with the write or read data phase.
- R5: If direction is sampled high while the engine is driving the command, address or write byte, the engine stops driving in the next cycle.
- R6: After an abort, the engine restarts the same operation from its command byte once direction is sampled low. It signals done only once, when an attempt completes.
- R7: The engine never starts driving a command byte while direction is high. A request accepted while direction is high waits until direction falls.
- R8: A request is accepted only while busy is low, and busy rises in the next cycle. Requests made while busy is high are ignored, and the operation in progress uses the fields captured at acceptance.
- R9: A read whose direction line has dropped by the data-capture edge is treated as aborted. It produces no done and is retried.
- R10: While no NXT and no direction is sampled, a byte being driven by the link stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_ext | input | 1 | 1 = use extended addressing |
| req_addr | input | DW | Register address |
| req_wdata | input | DW | Write data |
| req_busy | output | 1 | Operation in progress |
| req_done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle pulse, read data is valid |
| rd_data | output | DW | Last byte read |
| ulpi_dir | input | 1 | PHY bus direction (high = PHY drives) |
| ulpi_nxt | input | 1 | PHY throttle / accept |
| ulpi_stp | output | 1 | Link stop strobe |
| ulpi_data_i | input | DW | Data from PHY |
| ulpi_data_o | output | DW | Data to PHY |
| ulpi_data_oe | output | 1 | Link drives the data bus |

## Verification
The checker verifies on every cycle that the link stops driving one cycle after direction is seen high, that a command never starts right after direction was high, that stop follows an accepted byte, that driven bytes hold while not accepted, and that the done, read-valid and busy strobes stay consistent. The exact byte values (command encoding, extended address, write data), the retry back to the command byte after each kind of abort, the read capture timing and the handling of requests made while busy can only be shown by the bench's scenarios. These scenarios sweep all four operation types over many addresses and NXT delays, and inject aborts at every phase.

// File: rtl/ulpi_reg_pkg.sv
package ulpi_reg_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_HOLD  = 3'd1,
    SQ_CMD   = 3'd2,
    SQ_ADDR  = 3'd3,
    SQ_WDATA = 3'd4,
    SQ_STOP  = 3'd5,
    SQ_RWAIT = 3'd6,
    SQ_RDAT  = 3'd7
  } seq_state_t;

  localparam logic [1:0] OP_WR_CODE = 2'b10;
  localparam logic [1:0] OP_RD_CODE = 2'b11;
endpackage

// File: rtl/ulpi_req_port.sv
module ulpi_req_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_ext,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          finish,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          rdv,
  output logic [DW-1:0] rdata,
  output logic          lat_write,
  output logic          lat_ext,
  output logic [DW-1:0] lat_addr,
  output logic [DW-1:0] lat_wdata
);
  assign accept = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      rdv       <= 1'b0;
      rdata     <= '0;
      lat_write <= 1'b0;
      lat_ext   <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      done <= finish;
      rdv  <= capture;
      if (capture) rdata <= bus_in;
      if (accept) begin
        busy      <= 1'b1;
        lat_write <= req_write;
        lat_ext   <= req_ext;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end else if (finish) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ulpi_seq_fsm.sv
module ulpi_seq_fsm
  import ulpi_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       op_write,
  input  logic       op_ext,
  input  logic       dir,
  input  logic       nxt,
  output seq_state_t state_d,
  output logic       finish,
  output logic       capture
);
  seq_state_t state_q;

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      SQ_IDLE:  if (start) state_d = dir ? SQ_HOLD : SQ_CMD;
      SQ_HOLD:  if (!dir) state_d = SQ_CMD;
      SQ_CMD: begin
        if (dir)      state_d = SQ_HOLD;
        else if (nxt) state_d = op_ext ? SQ_ADDR : (op_write ? SQ_WDATA : SQ_RWAIT);
      end
      SQ_ADDR: begin
        if (dir)      state_d = SQ_HOLD;
        else if (nxt) state_d = op_write ? SQ_WDATA : SQ_RWAIT;
      end
      SQ_WDATA: begin
        if (dir)      state_d = SQ_HOLD;
        else if (nxt) state_d = SQ_STOP;
      end
      SQ_STOP: begin
        state_d = SQ_IDLE;
        finish  = 1'b1;
      end
      SQ_RWAIT: if (dir) state_d = SQ_RDAT;
      SQ_RDAT: begin
        if (dir) begin
          state_d = SQ_IDLE;
          finish  = 1'b1;
          capture = 1'b1;
        end else begin
          state_d = SQ_HOLD;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SQ_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/ulpi_bus_out.sv
module ulpi_bus_out
  import ulpi_reg_pkg::*;
#(
  parameter int               DW       = 8,
  parameter logic [DW-3:0]    EXT_CODE = 'h2F
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_t    state_d,
  input  logic          op_write,
  input  logic          op_ext,
  input  logic [DW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic [DW-1:0] data_o,
  output logic          oe,
  output logic          stp
);
  localparam int IMM_AW = DW - 2;

  logic [DW-1:0]     cmd_byte;
  logic [IMM_AW-1:0] addr_field;

  assign addr_field = op_ext ? EXT_CODE : op_addr[IMM_AW-1:0];
  assign cmd_byte   = {(op_write ? OP_WR_CODE : OP_RD_CODE), addr_field};

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      oe     <= 1'b0;
      stp    <= 1'b0;
    end else begin
      data_o <= '0;
      oe     <= 1'b0;
      stp    <= 1'b0;
      case (state_d)
        SQ_CMD:   begin oe <= 1'b1; data_o <= cmd_byte; end
        SQ_ADDR:  begin oe <= 1'b1; data_o <= op_addr; end
        SQ_WDATA: begin oe <= 1'b1; data_o <= op_wdata; end
        SQ_STOP:  begin oe <= 1'b1; stp <= 1'b1; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/ulpi_reg_engine.sv
module ulpi_reg_engine
  import ulpi_reg_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-3:0] EXT_CODE = 'h2F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_ext,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_busy,
  output logic          req_done,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          ulpi_dir,
  input  logic          ulpi_nxt,
  output logic          ulpi_stp,
  input  logic [DW-1:0] ulpi_data_i,
  output logic [DW-1:0] ulpi_data_o,
  output logic          ulpi_data_oe
);
  logic          accept, finish, capture;
  logic          lat_write, lat_ext;
  logic [DW-1:0] lat_addr, lat_wdata;
  logic          cur_write, cur_ext;
  logic [DW-1:0] cur_addr, cur_wdata;
  seq_state_t    state_d;

  assign cur_write = accept ? req_write : lat_write;
  assign cur_ext   = accept ? req_ext   : lat_ext;
  assign cur_addr  = accept ? req_addr  : lat_addr;
  assign cur_wdata = accept ? req_wdata : lat_wdata;

  ulpi_req_port #(.DW(DW)) u_port (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_ext(req_ext),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .finish(finish), .capture(capture), .bus_in(ulpi_data_i),
    .accept(accept), .busy(req_busy), .done(req_done),
    .rdv(rd_valid), .rdata(rd_data),
    .lat_write(lat_write), .lat_ext(lat_ext),
    .lat_addr(lat_addr), .lat_wdata(lat_wdata)
  );

  ulpi_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(accept),
    .op_write(cur_write), .op_ext(cur_ext),
    .dir(ulpi_dir), .nxt(ulpi_nxt),
    .state_d(state_d), .finish(finish), .capture(capture)
  );

  ulpi_bus_out #(.DW(DW), .EXT_CODE(EXT_CODE)) u_out (
    .clk(clk), .rst(rst), .state_d(state_d),
    .op_write(cur_write), .op_ext(cur_ext),
    .op_addr(cur_addr), .op_wdata(cur_wdata),
    .data_o(ulpi_data_o), .oe(ulpi_data_oe), .stp(ulpi_stp)
  );
endmodule

// File: rtl/ulpi_reg_engine_chk.sv
module ulpi_reg_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_busy,
  input logic          req_done,
  input logic          rd_valid,
  input logic          ulpi_dir,
  input logic          ulpi_nxt,
  input logic          ulpi_stp,
  input logic [DW-1:0] ulpi_data_o,
  input logic          ulpi_data_oe
);
  // R5
  dir_yield_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ulpi_dir) |-> !ulpi_data_oe);

  // R7
  cmd_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ulpi_data_oe && !$past(ulpi_data_oe)) |-> !$past(ulpi_dir));

  // R2
  stp_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ulpi_stp |-> ($past(ulpi_nxt) && ulpi_data_oe && ulpi_data_o == '0));

  // R10
  hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (ulpi_data_oe && $past(ulpi_data_oe) && !$past(ulpi_nxt) && !$past(ulpi_dir))
      |-> $stable(ulpi_data_o));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_done |-> !req_busy);

  // R3
  rdv_done_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> req_done);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);
endmodule

bind ulpi_reg_engine ulpi_reg_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_busy(req_busy), .req_done(req_done),
  .rd_valid(rd_valid), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
  .ulpi_stp(ulpi_stp), .ulpi_data_o(ulpi_data_o), .ulpi_data_oe(ulpi_data_oe)
);

// File: tb/ulpi_reg_engine_tb.sv
`timescale 1ns/1ps
module ulpi_reg_engine_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0, req_ext = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_busy, req_done, rd_valid;
  logic [7:0] rd_data;
  logic       ulpi_dir = 1'b0, ulpi_nxt = 1'b0, ulpi_stp;
  logic [7:0] ulpi_data_i = '0, ulpi_data_o;
  logic       ulpi_data_oe;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ulpi_reg_engine u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_ext(req_ext), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_busy(req_busy), .req_done(req_done), .rd_valid(rd_valid),
    .rd_data(rd_data), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
    .ulpi_stp(ulpi_stp), .ulpi_data_i(ulpi_data_i),
    .ulpi_data_o(ulpi_data_o), .ulpi_data_oe(ulpi_data_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic abort_seq();
    ulpi_dir = 1'b1;
    @(negedge clk);
    chk("R5 bus released after dir", {31'd0, ulpi_data_oe}, 32'd0);
    @(negedge clk);
    chk("R7 no command while dir high", {30'd0, ulpi_data_oe, req_busy}, 32'd1);
    ulpi_dir = 1'b0;
    @(negedge clk);
  endtask

  // ab: 0 none, 1 abort in command, 2 in address byte, 3 in write byte,
  //     4 read data phase drop, 5 dir high at request time
  task automatic run_op(input bit wr, input bit ex, input logic [7:0] a,
                        input logic [7:0] wd, input int dly, input int ab, input bit poke);
    logic [7:0] ec;
    logic [7:0] rv;
    string      ctag;
    bit         fin;
    ec   = {1'b1, ~wr, (ex ? 6'h2F : a[5:0])};
    rv   = (a * 8'd7) ^ 8'h3C;
    ctag = ex ? "R4 command byte" : (wr ? "R2 command byte" : "R3 command byte");
    fin  = 1'b0;
    if (ab == 5) ulpi_dir = 1'b1;
    req_valid = 1'b1; req_write = wr; req_ext = ex; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = ~wr; req_ext = ~ex; req_addr = ~a; req_wdata = ~wd;
    chk("R8 busy after accept", {31'd0, req_busy}, 32'd1);
    if (ab == 5) begin
      chk("R7 waits for dir low", {31'd0, ulpi_data_oe}, 32'd0);
      @(negedge clk);
      chk("R7 still waiting", {31'd0, ulpi_data_oe}, 32'd0);
      ulpi_dir = 1'b0;
      @(negedge clk);
    end
    for (int att = 0; att < 2 && !fin; att++) begin
      bit inj;
      inj = (att == 0);
      chk(att == 0 ? ctag : "R6 retry command byte", {23'd0, ulpi_data_oe, ulpi_data_o}, {23'd0, 1'b1, ec});
      if (inj && ab == 1) begin abort_seq(); continue; end
      for (int d = 0; d < dly; d++) begin
        if (poke && d == 0) begin
          req_valid = 1'b1; req_write = ~wr; req_addr = a + 8'd1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 command held", {23'd0, ulpi_data_oe, ulpi_data_o}, {23'd0, 1'b1, ec});
      end
      ulpi_nxt = 1'b1; @(negedge clk); ulpi_nxt = 1'b0;
      if (ex) begin
        chk("R4 address byte", {23'd0, ulpi_data_oe, ulpi_data_o}, {23'd0, 1'b1, a});
        if (inj && ab == 2) begin abort_seq(); continue; end
        ulpi_nxt = 1'b1; @(negedge clk); ulpi_nxt = 1'b0;
      end
      if (wr) begin
        chk("R2 write byte", {23'd0, ulpi_data_oe, ulpi_data_o}, {23'd0, 1'b1, wd});
        if (inj && ab == 3) begin abort_seq(); continue; end
        ulpi_nxt = 1'b1; @(negedge clk); ulpi_nxt = 1'b0;
        chk("R2 stop strobe", {22'd0, ulpi_stp, ulpi_data_oe, ulpi_data_o}, {22'd0, 2'b11, 8'd0});
        @(negedge clk);
        chk("R2 done", {28'd0, req_done, req_busy, ulpi_stp, ulpi_data_oe}, 32'b1000);
        fin = 1'b1;
      end else begin
        chk("R3 bus released after command", {31'd0, ulpi_data_oe}, 32'd0);
        ulpi_dir = 1'b1;
        @(negedge clk);
        chk("R3 turnaround", {30'd0, ulpi_data_oe, req_done}, 32'd0);
        if (inj && ab == 4) begin
          ulpi_dir = 1'b0;
          @(negedge clk);
          chk("R9 no done on dropped read", {29'd0, req_done, ulpi_data_oe, req_busy}, 32'b001);
          @(negedge clk);
          continue;
        end
        ulpi_data_i = rv;
        @(negedge clk);
        ulpi_dir = 1'b0;
        chk("R3 read result", {21'd0, req_done, rd_valid, req_busy, rd_data}, {21'd0, 3'b110, rv});
        fin = 1'b1;
      end
    end
    @(negedge clk);
    chk(poke ? "R8 busy request ignored" : "R6 single done",
        {29'd0, req_done, req_busy, ulpi_data_oe}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {19'd0, req_busy, req_done, rd_valid, ulpi_stp, ulpi_data_oe, ulpi_data_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {19'd0, req_busy, req_done, rd_valid, ulpi_stp, ulpi_data_oe, ulpi_data_o}, 32'd0);
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] a, wd;
        a  = 8'(k * 43 + op * 17 + 1);
        wd = 8'((k * 29) ^ (op * 85));
        run_op(op[0], op[1], a, wd, k % 3, 0, k == 2);
      end
    end
    for (int op = 0; op < 4; op++) begin
      bit wr, ex;
      wr = op[0]; ex = op[1];
      run_op(wr, ex, 8'(8'hC3 + op), 8'(8'h5A ^ op), 1, 1, 1'b0);
      if (ex) run_op(wr, ex, 8'(8'h91 + op), 8'h77, 0, 2, 1'b0);
      if (wr) run_op(wr, ex, 8'(8'h2E + op), 8'hE1, 2, 3, 1'b0);
      else    run_op(wr, ex, 8'(8'h3F - op), 8'h00, 1, 4, 1'b0);
      run_op(wr, ex, 8'(8'h10 * op + 3), 8'h99, 0, 5, 1'b0);
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule